// File: doc/BRIEF.md
# Command Bus Parity Error Checker

This block watches a registered DRAM address and command bus and confirms even parity across it. On every clock edge it captures the address, bank, row-strobe, column-strobe and write-enable inputs together with four active-low chip selects. The parity bit that covers a command word is sent one clock after the word. On the following edge the block combines that bit with the stored word. If the word was selected and the total number of high signals is odd, the block flags an error.

A flagged error does not appear on the output at once. It passes through a fixed delay pipeline and then pulls the active-low error output down for a fixed window. Errors that overlap restart the window. A synchronous reset drives the output high and clears every pipeline stage, so no error captured before reset can show up after it.

Top module: `cmd_parity_checker`

## Requirements
- R1: The parity group holds 22 signals: `addrIn[15:0]`, `bankIn[2:0]`, `rasN`, `casN` and `weN`. A word is correct when the number of high signals in the group, plus the parity bit, is even. An odd total is an error.
- R2: The chip-select inputs never enter the parity sum. A correctly paritied word gives no error whatever the pattern of selects, as long as at least one select is low.
- R3: The value of `parityIn` sampled on edge k is checked against the word sampled on edge k-1, and never against the word sampled on edge k.
- R4: For a failing word sampled on edge k, `errN` reads 0 after edge k+3 (ERR_DELAY = 3).
- R5: After the edge on which `errN` falls, it stays 0 for exactly two clock cycles (HOLD_CYCLES = 2) and then returns to 1, unless a new error arrives or reset is asserted.
- R6: A word sampled while all four `csN` bits are 1 is deselected. It never causes an error, whatever its parity.
- R7: A word is checked when any single bit of `csN` is 0. Each of the four selects enables the check on its own.
- R8: If a second error is due while `errN` is already 0, the two-cycle low window restarts from the cycle in which the second error is due to assert.
- R9: While `rst` is 1 on an edge, `errN` reads 1 after that edge. Any error whose word or parity bit was sampled before or during reset never appears on `errN`.
- R10: A stream of correctly paritied selected words keeps `errN` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addrIn | input | 16 | Address lines of the command word |
| bankIn | input | 3 | Bank-address lines of the command word |
| rasN | input | 1 | Row strobe, part of the parity group |
| casN | input | 1 | Column strobe, part of the parity group |
| weN | input | 1 | Write enable, part of the parity group |
| csN | input | 4 | Active-low chip selects; they qualify the check and are not in the parity group |
| parityIn | input | 1 | Even-parity bit for the word sampled on the previous edge |
| errN | output | 1 | Active-low parity error flag |

## Verification
On every cycle the assertions check three things. A failing selected word must drive `errN` low after the exact delay. Every low cycle must trace back to such a word inside the hold window. Reset must force the output high. The random and directed scenarios are needed for the rest: that the chip selects never change the parity sum, that each single select enables the check, that the parity bit is paired with the previous word rather than the current one, and that overlapping errors restart the window. These depend on particular input patterns, so only the bench's compare of the full output sequence against its own model can show them.

// File: rtl/cmdpar_pkg.sv
package cmdpar_pkg;

  // Strobes sent from the control path to the datapath.
  typedef struct packed {
    logic flush;    // clear every captured word and the pending mismatch
    logic capture;  // take a new word and evaluate the pending one
  } ctlStrobes_t;

  // Number of non-address, non-bank signals in the parity group.
  localparam int STROBE_BITS = 3;

endpackage

// File: rtl/cmdpar_datapath.sv
module cmdpar_datapath
  import cmdpar_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3,
  parameter int CS_W   = 4
) (
  input  logic              clk,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [CS_W-1:0]   csN,
  input  logic              parityIn,
  output logic              mismatch
);

  localparam int GRP_W = ADDR_W + BANK_W + STROBE_BITS;

  logic [GRP_W-1:0] wordQ;
  logic             selQ;
  logic             wordOdd;

  // Odd count over the captured group; the selects are deliberately left out.
  assign wordOdd = ^wordQ;

  always_ff @(posedge clk) begin
    if (strobes.flush) begin
      wordQ    <= '0;
      selQ     <= 1'b0;
      mismatch <= 1'b0;
    end else if (strobes.capture) begin
      wordQ    <= {addrIn, bankIn, rasN, casN, weN};
      selQ     <= ~&csN;
      // The parity bit on this edge belongs to the word held since the last one.
      mismatch <= selQ & (wordOdd ^ parityIn);
    end
  end

endmodule

// File: rtl/cmdpar_control.sv
module cmdpar_control
  import cmdpar_pkg::*;
#(
  parameter int ERR_DELAY   = 3,
  parameter int HOLD_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mismatch,
  output ctlStrobes_t strobes,
  output logic        errN
);

  // The datapath has already spent two edges (word, then parity/compare).
  localparam int PIPE_LEN = ERR_DELAY - 2;
  localparam int CNT_W    = $clog2(HOLD_CYCLES + 1);

  logic             pipeOut;
  logic [CNT_W-1:0] holdCnt;

  always_comb begin
    strobes.flush   = rst;
    strobes.capture = ~rst;
  end

  generate
    if (PIPE_LEN > 0) begin : g_pipe
      logic [PIPE_LEN-1:0] delayQ;
      always_ff @(posedge clk) begin
        if (rst) delayQ <= '0;
        else     delayQ <= {delayQ[PIPE_LEN-2+1:0] << 1} | PIPE_LEN'(mismatch);
      end
      assign pipeOut = delayQ[PIPE_LEN-1];
    end else begin : g_direct
      assign pipeOut = mismatch;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
      errN    <= 1'b1;
    end else begin
      // A new error reloads the window; otherwise the window drains.
      if (pipeOut)             holdCnt <= CNT_W'(HOLD_CYCLES - 1);
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
      errN <= ~(pipeOut | (holdCnt != '0));
    end
  end

endmodule

// File: rtl/cmd_parity_checker.sv
module cmd_parity_checker
  import cmdpar_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int CS_W        = 4,
  parameter int ERR_DELAY   = 3,
  parameter int HOLD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [CS_W-1:0]   csN,
  input  logic              parityIn,
  output logic              errN
);

  ctlStrobes_t strobes;
  logic        mismatch;

  cmdpar_datapath #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CS_W(CS_W)
  ) u_datapath (
    .clk(clk), .strobes(strobes), .addrIn(addrIn), .bankIn(bankIn),
    .rasN(rasN), .casN(casN), .weN(weN), .csN(csN),
    .parityIn(parityIn), .mismatch(mismatch)
  );

  cmdpar_control #(
    .ERR_DELAY(ERR_DELAY), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_control (
    .clk(clk), .rst(rst), .mismatch(mismatch),
    .strobes(strobes), .errN(errN)
  );

endmodule

// File: rtl/cmd_parity_checker_sva.sv
module cmd_parity_checker_sva #(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 3,
  parameter int CS_W        = 4,
  parameter int ERR_DELAY   = 3,
  parameter int HOLD_CYCLES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic [BANK_W-1:0] bankIn,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [CS_W-1:0]   csN,
  input logic              parityIn,
  input logic              errN
);

  localparam int GRP_W  = ADDR_W + BANK_W + 3;
  localparam int HIST_D = ERR_DELAY + HOLD_CYCLES - 1;

  logic [GRP_W-1:0]  prevWord;
  logic              prevSel;
  logic              evNow;
  logic [HIST_D-1:0] evHist;

  // Independent view of a failing word, taken from the ports only.
  assign evNow = prevSel & ((^prevWord) ^ parityIn);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevWord <= '0;
      prevSel  <= 1'b0;
      evHist   <= '0;
    end else begin
      prevWord <= {addrIn, bankIn, rasN, casN, weN};
      prevSel  <= ~&csN;
      evHist   <= {evHist[HIST_D-2:0], evNow};
    end
  end

  // R4: a failing selected word shows up low after the fixed delay.
  assert_low_after_delay_R4: assert property (@(posedge clk) disable iff (rst)
    evHist[ERR_DELAY-1] |-> !errN);

  // R5 / R6: every low cycle is explained by a selected failing word in the window.
  assert_low_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    !errN |-> (|evHist[ERR_DELAY-1 +: HOLD_CYCLES]));

  // R9: reset drives the flag high.
  assert_reset_high_R9: assert property (@(posedge clk)
    rst |=> errN);

  generate
    if (HOLD_CYCLES > 1) begin : g_hold
      // R5: once low, the flag is not released on the next cycle.
      assert_min_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(errN) |=> !errN);
    end
  endgenerate

endmodule

bind cmd_parity_checker cmd_parity_checker_sva #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CS_W(CS_W),
  .ERR_DELAY(ERR_DELAY), .HOLD_CYCLES(HOLD_CYCLES)
) u_sva (
  .clk(clk), .rst(rst), .addrIn(addrIn), .bankIn(bankIn),
  .rasN(rasN), .casN(casN), .weN(weN), .csN(csN),
  .parityIn(parityIn), .errN(errN)
);

// File: tb/cmd_parity_checker_bench.sv
module cmd_parity_checker_bench;

  localparam int MAXC = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addrIn = '0;
  logic [2:0]  bankIn = '0;
  logic        rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [3:0]  csN = 4'hF;
  logic        parityIn = 1'b0;
  logic        errN;

  cmd_parity_checker u_cmd_parity_checker (
    .clk(clk), .rst(rst), .addrIn(addrIn), .bankIn(bankIn),
    .rasN(rasN), .casN(casN), .weN(weN), .csN(csN),
    .parityIn(parityIn), .errN(errN)
  );

  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    n      = 0;
  bit    done   = 0;
  bit    lastPar = 0;
  bit    wordOddA [MAXC];
  bit    selA     [MAXC];
  bit    parA     [MAXC];
  bit    rstA     [MAXC];
  string tagA     [MAXC];

  // Expected errN after edge m: low when a selected failing word was sampled
  // on edge k-1 with its parity on edge k, and m is k+2 or k+3, with no reset
  // on any edge from k-1 through m.
  function automatic bit expErrN(int m);
    for (int j = 2; j <= 3; j++) begin
      int  k = m - j;
      bit  clean = 1;
      if (k < 1) continue;
      for (int e = k - 1; e <= m; e++) if (rstA[e]) clean = 0;
      if (clean && selA[k-1] && (wordOddA[k-1] ^ parA[k])) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic checkOut(int m);
    bit exp = expErrN(m);
    checks++;
    if (errN !== exp) begin
      fails++;
      $display("FAIL %s: cycle %0d errN=%b expected %b", tagA[m], m, errN, exp);
    end
  endtask

  // One cycle: check the result of the last edge, then drive the next word.
  // flip=1 makes parityIn wrong for the word driven on the previous step.
  task automatic step(input logic [15:0] a, input logic [2:0] b, input logic [2:0] c,
                      input logic [3:0] cs, input bit flip, input bit r, input string tag);
    @(negedge clk);
    if (n > 0) checkOut(n - 1);
    addrIn = a; bankIn = b; {rasN, casN, weN} = c; csN = cs; rst = r;
    parityIn = lastPar ^ flip;
    wordOddA[n] = ^{a, b, c};
    selA[n] = ~&cs;
    parA[n] = parityIn;
    rstA[n] = r;
    tagA[n] = tag;
    lastPar = ^{a, b, c};
    @(posedge clk);
    n++;
  endtask

  task automatic good(int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(16'h1234 + 16'(i), 3'(i), 3'b101, 4'b1110, 0, 0, tag);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: cycle %0d expected completion", n);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    int unused;
    unused = $urandom(32'h5eed_1234);
    // R9: reset state
    for (int i = 0; i < 3; i++) step('0, '0, 3'b111, 4'hF, 0, 1, "R9");
    good(4, "R10");
    // R4 / R5: a single bad word, then watch the two-cycle window
    step(16'hA5A5, 3'b010, 3'b011, 4'b1110, 0, 0, "R4");
    step(16'h0001, 3'b000, 3'b111, 4'b1110, 1, 0, "R4");
    good(6, "R5");
    // R6: deselected bad word
    step(16'hFFFF, 3'b111, 3'b000, 4'b1111, 0, 0, "R6");
    step(16'h0000, 3'b000, 3'b111, 4'b1110, 1, 0, "R6");
    good(5, "R6");
    // R7: each select alone enables the check
    for (int i = 0; i < 4; i++) begin
      step(16'h0F0F, 3'b001, 3'b110, ~(4'b0001 << i), 0, 0, "R7");
      step(16'h3333, 3'b100, 3'b101, 4'b1111, 1, 0, "R7");
      good(4, "R7");
    end
    // R3: parity right for the current word but wrong for the previous one
    step(16'h0001, 3'b000, 3'b000, 4'b1110, 0, 0, "R3");
    step(16'h0003, 3'b000, 3'b000, 4'b1110, 1, 0, "R3");
    good(5, "R3");
    // R3: parity right for the previous word, odd current word: no error there
    step(16'h0007, 3'b000, 3'b000, 4'b1110, 0, 0, "R3");
    step(16'h0000, 3'b000, 3'b000, 4'b1111, 0, 0, "R3");
    good(5, "R3");
    // R8: back-to-back errors and an error one cycle apart
    step(16'h1111, 3'b011, 3'b010, 4'b1101, 0, 0, "R8");
    step(16'h2222, 3'b011, 3'b010, 4'b1101, 1, 0, "R8");
    step(16'h3333, 3'b011, 3'b010, 4'b1101, 1, 0, "R8");
    good(6, "R8");
    step(16'h4444, 3'b001, 3'b001, 4'b1011, 0, 0, "R8");
    step(16'h5555, 3'b001, 3'b001, 4'b1011, 1, 0, "R8");
    step(16'h6666, 3'b001, 3'b001, 4'b1011, 0, 0, "R8");
    step(16'h7777, 3'b001, 3'b001, 4'b1011, 1, 0, "R8");
    good(7, "R8");
    // R9: reset between a failing word and its output flushes it
    step(16'h8888, 3'b110, 3'b100, 4'b0111, 0, 0, "R9");
    step(16'h9999, 3'b110, 3'b100, 4'b0111, 1, 0, "R9");
    step(16'h0000, 3'b000, 3'b111, 4'hF, 0, 1, "R9");
    good(6, "R9");
    // R2: same correct words under several select patterns
    for (int i = 0; i < 6; i++) begin
      logic [3:0] pat;
      pat = (i % 3 == 0) ? 4'b0000 : (i % 3 == 1) ? 4'b0101 : 4'b1010;
      step(16'hC3C3 ^ 16'(i), 3'(i), 3'b011, pat, 0, 0, "R2");
    end
    good(4, "R2");
    // R1: random words, selects, parity faults and rare resets
    for (int i = 0; i < 2500; i++) begin
      logic [3:0] cs;
      bit flip, r;
      cs   = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
      flip = ($urandom % 5 == 0);
      r    = ($urandom % 50 == 0);
      step(16'($urandom), 3'($urandom), 3'($urandom), cs, flip, r, "R1");
    end
    good(5, "R10");
    @(negedge clk);
    checkOut(n - 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule